// File: doc/BRIEF.md
# Condition Register Field Move Unit

This block holds a 32-bit condition register divided into eight 4-bit fields and carries out three narrow move operations on it. One operation takes the four arithmetic status flags (overflow, 32-bit overflow, carry, 32-bit carry) and deposits them, packed into a nibble, into a field picked by a 3-bit index. A second operation replaces exactly one field with the matching nibble of a 64-bit source word. The field is picked by an 8-bit one-hot mask. A third operation returns exactly one field as a 64-bit result word with all other bits zero, and raises a write-enable for the destination.

Both mask-driven operations act only when the mask has exactly one bit set. With a zero mask, or with two or more bits set, nothing is written: the register keeps its value and the read result is not enabled. The register changes on the rising clock edge. The read result is combinational from the register's current contents, so it reflects the value held before that edge.

Field numbering runs from the top down. Field index 0 is bits 31:28 and field index 7 is bits 3:0. Mask bit 7 selects field 0 and mask bit 0 selects field 7, so mask bit p covers register bits 4p+3:4p.

Top module: `cr_field_mover`

## Requirements
- R1: A synchronous active-high `rst` clears `cr_value` to zero at the next rising edge, whatever operation is presented.
- R2: With `op_valid`=1 and `op_code`=2'b01, the next edge writes the nibble {ov, ov32, ca, ca32} (ov in bit 3, ca32 in bit 0) into field `fld_idx`. Field index i occupies bits (7-i)*4+3:(7-i)*4. The other seven fields keep their values.
- R3: With `op_valid`=1, `op_code`=2'b10 and exactly one bit p of `fld_mask` set, the next edge copies `src_word[4p+3:4p]` into `cr_value[4p+3:4p]`. All other register bits are unchanged, and `src_word[63:32]` has no effect.
- R4: With `op_code`=2'b10 and a `fld_mask` that is zero or has two or more bits set, the register is not modified.
- R5: With `op_valid`=1, `op_code`=2'b11 and exactly one bit p of `fld_mask` set, `rd_we` is 1 in the same cycle. `rd_word` then equals `cr_value[4p+3:4p]` in bits 4p+3:4p, and zero in every other bit of the 64.
- R6: `rd_we` is 0, and `rd_word` is zero, for a read whose mask is not one-hot and for every operation other than a read.
- R7: A read operation never modifies the register.
- R8: With `op_valid`=0, or with `op_code`=2'b00, the register holds its value and `rd_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00 idle, 01 status-to-field, 10 field write, 11 field read |
| fld_idx | input | 3 | Field index for status-to-field (0 = bits 31:28) |
| fld_mask | input | 8 | One-hot field mask for write and read (bit p = bits 4p+3:4p) |
| src_word | input | 64 | Source word; low 32 bits feed the field write |
| st_ov | input | 1 | Overflow flag |
| st_ov32 | input | 1 | 32-bit overflow flag |
| st_ca | input | 1 | Carry flag |
| st_ca32 | input | 1 | 32-bit carry flag |
| cr_value | output | 32 | Current condition register contents |
| rd_word | output | 64 | Field read result, zero-extended |
| rd_we | output | 1 | Destination write-enable for the read result |

## Verification
The status move is driven with flag patterns 1010, 0101, 1111 and 0000 at the top, bottom and a middle field. These patterns tell the bit order of the pack apart, and show whether the index counts from the correct end. Field writes use single-bit masks at both ends and in the middle, with source words whose nibbles differ and whose upper half is all ones. This exposes a wrong lane, a leak of neighbouring nibbles or use of the upper half. Masks of zero and of two bits separate a true one-hot test from a "highest bit wins" shortcut. Reads of fields holding distinct digits check both the selected nibble and the clearing of everything else.

// File: rtl/crfm_pkg.sv
package crfm_pkg;

   typedef enum logic [1:0] {
      OPC_IDLE   = 2'b00,
      OPC_STATUS = 2'b01,
      OPC_FWRITE = 2'b10,
      OPC_FREAD  = 2'b11
   } crfm_op_e;

   typedef struct packed {
      logic ov;
      logic ov32;
      logic ca;
      logic ca32;
   } crfm_status_t;

   localparam int STATUS_BITS = 4;

endpackage

// File: rtl/crfm_mask_decode.sv
// Field mask decoder: finds the highest set bit and reports whether
// the mask is one-hot.
module crfm_mask_decode #(
   parameter int NUM_FIELDS = 8
) (
   input  logic [NUM_FIELDS-1:0] fld_mask,
   output logic                  one_hot,
   output logic [NUM_FIELDS-1:0] top_sel
);
   localparam int CNT_W = $clog2(NUM_FIELDS + 1);

   logic [CNT_W-1:0] set_cnt;
   logic             seen;

   generate
      if (NUM_FIELDS < 2) begin : g_bad_fields
         $error("crfm_mask_decode: NUM_FIELDS must be at least 2");
      end
   endgenerate

   // highest set bit wins
   always_comb begin
      top_sel = '0;
      seen    = 1'b0;
      for (int p = NUM_FIELDS - 1; p >= 0; p--) begin
         if (fld_mask[p] && !seen) begin
            top_sel[p] = 1'b1;
            seen       = 1'b1;
         end
      end
   end

   // population count
   always_comb begin
      set_cnt = '0;
      for (int p = 0; p < NUM_FIELDS; p++) begin
         set_cnt = set_cnt + CNT_W'(fld_mask[p]);
      end
   end

   assign one_hot = (set_cnt == CNT_W'(1));

endmodule

// File: rtl/crfm_index_decode.sv
// Converts a field index (0 = most significant field) into a one-hot
// select over field bit positions.
module crfm_index_decode #(
   parameter int NUM_FIELDS = 8,
   parameter int IDX_W      = $clog2(NUM_FIELDS)
) (
   input  logic [IDX_W-1:0]      fld_idx,
   output logic [NUM_FIELDS-1:0] pos_sel
);
   generate
      if ((1 << IDX_W) < NUM_FIELDS) begin : g_bad_idx
         $error("crfm_index_decode: IDX_W too narrow for NUM_FIELDS");
      end
      for (genvar p = 0; p < NUM_FIELDS; p++) begin : g_pos
         localparam logic [IDX_W-1:0] IDX_OF_POS = IDX_W'(NUM_FIELDS - 1 - p);
         assign pos_sel[p] = (fld_idx == IDX_OF_POS);
      end
   endgenerate

endmodule

// File: rtl/crfm_status_pack.sv
// Packs the four status flags into one field-wide value.
module crfm_status_pack
   import crfm_pkg::*;
#(
   parameter int FIELD_W = 4
) (
   input  crfm_status_t       st,
   output logic [FIELD_W-1:0] nib
);
   generate
      if (FIELD_W == STATUS_BITS) begin : g_exact
         assign nib = {st.ov, st.ov32, st.ca, st.ca32};
      end else if (FIELD_W > STATUS_BITS) begin : g_wide
         assign nib = {{(FIELD_W - STATUS_BITS){1'b0}}, st.ov, st.ov32, st.ca, st.ca32};
      end else begin : g_narrow
         $error("crfm_status_pack: FIELD_W must hold four status bits");
      end
   endgenerate

endmodule

// File: rtl/crfm_cr_reg.sv
// Condition register storage with per-field write selects.
module crfm_cr_reg #(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   parameter int CR_W       = FIELD_W * NUM_FIELDS
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_FIELDS-1:0] wr_sel,
   input  logic [CR_W-1:0]       wr_data,
   output logic [CR_W-1:0]       cr_q
);
   logic [CR_W-1:0] cr_d;

   generate
      if (CR_W != FIELD_W * NUM_FIELDS) begin : g_bad_width
         $error("crfm_cr_reg: CR_W must equal FIELD_W * NUM_FIELDS");
      end
   endgenerate

   always_comb begin
      cr_d = cr_q;
      for (int p = 0; p < NUM_FIELDS; p++) begin
         if (wr_sel[p]) begin
            cr_d[p*FIELD_W +: FIELD_W] = wr_data[p*FIELD_W +: FIELD_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cr_q <= '0;
      end else begin
         cr_q <= cr_d;
      end
   end

endmodule

// File: rtl/cr_field_mover.sv
// Condition register field move unit: status-to-field, single-field
// write and single-field read.
module cr_field_mover
   import crfm_pkg::*;
#(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   parameter int SRC_W      = 64,
   parameter int RES_W      = 64
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                op_valid,
   input  logic [1:0]                          op_code,
   input  logic [$clog2(NUM_FIELDS)-1:0]       fld_idx,
   input  logic [NUM_FIELDS-1:0]               fld_mask,
   input  logic [SRC_W-1:0]                    src_word,
   input  logic                                st_ov,
   input  logic                                st_ov32,
   input  logic                                st_ca,
   input  logic                                st_ca32,
   output logic [FIELD_W*NUM_FIELDS-1:0]       cr_value,
   output logic [RES_W-1:0]                    rd_word,
   output logic                                rd_we
);
   localparam int CR_W  = FIELD_W * NUM_FIELDS;
   localparam int IDX_W = $clog2(NUM_FIELDS);

   generate
      if (CR_W > SRC_W) begin : g_bad_src
         $error("cr_field_mover: SRC_W narrower than the register");
      end
      if (CR_W > RES_W) begin : g_bad_res
         $error("cr_field_mover: RES_W narrower than the register");
      end
   endgenerate

   crfm_op_e               op;
   logic                   is_status;
   logic                   is_fwrite;
   logic                   is_fread;
   logic                   mask_one_hot;
   logic [NUM_FIELDS-1:0]  mask_top_sel;
   logic [NUM_FIELDS-1:0]  idx_pos_sel;
   logic [FIELD_W-1:0]     status_nib;
   logic [NUM_FIELDS-1:0]  wr_sel;
   logic [CR_W-1:0]        wr_data;
   logic [CR_W-1:0]        cr_q;
   logic [CR_W-1:0]        rd_bit_mask;
   logic                   rd_hit;
   crfm_status_t           st_bundle;
   logic                   unused_src_hi;

   assign op        = crfm_op_e'(op_code);
   assign is_status = op_valid && (op == OPC_STATUS);
   assign is_fwrite = op_valid && (op == OPC_FWRITE);
   assign is_fread  = op_valid && (op == OPC_FREAD);

   assign st_bundle = '{ov: st_ov, ov32: st_ov32, ca: st_ca, ca32: st_ca32};

   crfm_mask_decode #(
      .NUM_FIELDS (NUM_FIELDS)
   ) i_mask_decode (
      .fld_mask (fld_mask),
      .one_hot  (mask_one_hot),
      .top_sel  (mask_top_sel)
   );

   crfm_index_decode #(
      .NUM_FIELDS (NUM_FIELDS),
      .IDX_W      (IDX_W)
   ) i_index_decode (
      .fld_idx (fld_idx),
      .pos_sel (idx_pos_sel)
   );

   crfm_status_pack #(
      .FIELD_W (FIELD_W)
   ) i_status_pack (
      .st  (st_bundle),
      .nib (status_nib)
   );

   // write steering
   always_comb begin
      wr_sel  = '0;
      wr_data = src_word[CR_W-1:0];
      if (is_status) begin
         wr_sel  = idx_pos_sel;
         wr_data = {NUM_FIELDS{status_nib}};
      end else if (is_fwrite && mask_one_hot) begin
         wr_sel  = mask_top_sel;
      end
   end

   crfm_cr_reg #(
      .FIELD_W    (FIELD_W),
      .NUM_FIELDS (NUM_FIELDS),
      .CR_W       (CR_W)
   ) i_cr_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .cr_q    (cr_q)
   );

   // read path: expand field select into a bit mask
   generate
      for (genvar p = 0; p < NUM_FIELDS; p++) begin : g_rd_mask
         assign rd_bit_mask[p*FIELD_W +: FIELD_W] = {FIELD_W{mask_top_sel[p]}};
      end
      if (SRC_W > CR_W) begin : g_src_hi
         assign unused_src_hi = ^src_word[SRC_W-1:CR_W];
      end else begin : g_src_exact
         assign unused_src_hi = 1'b0;
      end
   endgenerate

   assign rd_hit   = is_fread && mask_one_hot;
   assign rd_we    = rd_hit;
   assign rd_word  = rd_hit ? RES_W'(cr_q & rd_bit_mask) : '0;
   assign cr_value = cr_q;

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cr_value == '0)); // R1

   AST_STATUS_LANDS: assert property (@(posedge clk) disable iff (rst)
      is_status |=> (cr_value[(NUM_FIELDS - 1 - int'($past(fld_idx))) * FIELD_W +: FIELD_W]
                     == FIELD_W'({$past(st_ov), $past(st_ov32), $past(st_ca), $past(st_ca32)}))); // R2

   AST_WRITE_REJECT: assert property (@(posedge clk) disable iff (rst)
      (is_fwrite && ($countones(fld_mask) != 1)) |=> $stable(cr_value)); // R4

   AST_READ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      rd_we |-> ($countones(fld_mask) == 1)); // R6

   AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      is_fread |=> $stable(cr_value)); // R7

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!op_valid || (op_code == 2'b00)) |=> $stable(cr_value)); // R8

endmodule

// File: tb/test_cr_field_mover.sv
`timescale 1ns/1ps
module test_cr_field_mover;

   localparam real CLK_HALF = 2.5;

   logic        clk = 1'b0;
   logic        rst;
   logic        op_valid;
   logic [1:0]  op_code;
   logic [2:0]  fld_idx;
   logic [7:0]  fld_mask;
   logic [63:0] src_word;
   logic        st_ov, st_ov32, st_ca, st_ca32;
   logic [31:0] cr_value;
   logic [63:0] rd_word;
   logic        rd_we;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   cr_field_mover i_cr_field_mover (
      .clk      (clk),
      .rst      (rst),
      .op_valid (op_valid),
      .op_code  (op_code),
      .fld_idx  (fld_idx),
      .fld_mask (fld_mask),
      .src_word (src_word),
      .st_ov    (st_ov),
      .st_ov32  (st_ov32),
      .st_ca    (st_ca),
      .st_ca32  (st_ca32),
      .cr_value (cr_value),
      .rd_word  (rd_word),
      .rd_we    (rd_we)
   );

   typedef struct packed {
      logic        vld;
      logic [1:0]  op;
      logic [2:0]  idx;
      logic [7:0]  msk;
      logic [63:0] src;
      logic [3:0]  st;
      logic [31:0] cr_exp;
      logic        we_exp;
      logic [63:0] rd_exp;
   } vec_t;

   localparam int NVEC = 16;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 2'd1, 3'd0, 8'h00, 64'h0, 4'hA, 32'hA0000000, 1'b0, 64'h0},
      '{1'b1, 2'd1, 3'd7, 8'h00, 64'h0, 4'h5, 32'hA0000005, 1'b0, 64'h0},
      '{1'b1, 2'd1, 3'd3, 8'h00, 64'h0, 4'hF, 32'hA00F0005, 1'b0, 64'h0},
      '{1'b1, 2'd2, 3'd0, 8'h40, 64'hFFFFFFFF_12345678, 4'h0, 32'hA20F0005, 1'b0, 64'h0},
      '{1'b1, 2'd2, 3'd0, 8'h01, 64'h00000000_9999999C, 4'h0, 32'hA20F000C, 1'b0, 64'h0},
      '{1'b1, 2'd2, 3'd0, 8'h00, 64'hFFFFFFFF_FFFFFFFF, 4'h0, 32'hA20F000C, 1'b0, 64'h0},
      '{1'b1, 2'd2, 3'd0, 8'h41, 64'hFFFFFFFF_FFFFFFFF, 4'h0, 32'hA20F000C, 1'b0, 64'h0},
      '{1'b1, 2'd3, 3'd0, 8'h80, 64'h0, 4'h0, 32'hA20F000C, 1'b1, 64'h00000000_A0000000},
      '{1'b1, 2'd3, 3'd0, 8'h10, 64'h0, 4'h0, 32'hA20F000C, 1'b1, 64'h00000000_000F0000},
      '{1'b1, 2'd3, 3'd0, 8'h03, 64'h0, 4'h0, 32'hA20F000C, 1'b0, 64'h0},
      '{1'b1, 2'd3, 3'd0, 8'h01, 64'h0, 4'h0, 32'hA20F000C, 1'b1, 64'h00000000_0000000C},
      '{1'b1, 2'd0, 3'd0, 8'h01, 64'hFFFFFFFF_FFFFFFFF, 4'hF, 32'hA20F000C, 1'b0, 64'h0},
      '{1'b1, 2'd1, 3'd0, 8'h00, 64'h0, 4'h0, 32'h020F000C, 1'b0, 64'h0},
      '{1'b1, 2'd2, 3'd0, 8'h80, 64'hAAAAAAAA_7BBBBBBB, 4'h0, 32'h720F000C, 1'b0, 64'h0},
      '{1'b0, 2'd2, 3'd0, 8'h01, 64'hFFFFFFFF_FFFFFFFF, 4'hF, 32'h720F000C, 1'b0, 64'h0},
      '{1'b0, 2'd3, 3'd0, 8'h01, 64'h0, 4'h0, 32'h720F000C, 1'b0, 64'h0}
   };

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string cr_tag(input vec_t v);
      if (!v.vld || v.op == 2'd0) return "R8";
      if (v.op == 2'd1) return "R2";
      if (v.op == 2'd2) return ($countones(v.msk) == 1) ? "R3" : "R4";
      return "R7";
   endfunction

   function automatic string rd_tag(input vec_t v);
      if (v.vld && v.op == 2'd3 && $countones(v.msk) == 1) return "R5";
      if (!v.vld || v.op == 2'd0) return "R8";
      return "R6";
   endfunction

   task automatic drive(input vec_t v);
      op_valid = v.vld;
      op_code  = v.op;
      fld_idx  = v.idx;
      fld_mask = v.msk;
      src_word = v.src;
      {st_ov, st_ov32, st_ca, st_ca32} = v.st;
   endtask

   initial begin
      rst      = 1'b1;
      op_valid = 1'b0;
      op_code  = 2'd0;
      fld_idx  = '0;
      fld_mask = '0;
      src_word = '0;
      {st_ov, st_ov32, st_ca, st_ca32} = 4'h0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "cr after reset", 64'(cr_value), 64'h0);
      @(negedge clk);
      rst = 1'b0;

      // vector walk
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         #1;
         chk(rd_tag(VEC[i]), $sformatf("rd_we vec %0d", i), 64'(rd_we), 64'(VEC[i].we_exp));
         chk(rd_tag(VEC[i]), $sformatf("rd_word vec %0d", i), rd_word, VEC[i].rd_exp);
         @(posedge clk);
         #1;
         chk(cr_tag(VEC[i]), $sformatf("cr vec %0d", i), 64'(cr_value), 64'(VEC[i].cr_exp));
      end

      // R1: reset wins over a status move in the same cycle
      @(negedge clk);
      drive('{1'b1, 2'd1, 3'd0, 8'h00, 64'h0, 4'hF, 32'h0, 1'b0, 64'h0});
      rst = 1'b1;
      @(posedge clk);
      #1;
      chk("R1", "cr after mid-run reset", 64'(cr_value), 64'h0);
      @(negedge clk);
      rst = 1'b0;

      // R5: read of a cleared register is enabled and reads zero
      drive('{1'b1, 2'd3, 3'd0, 8'h08, 64'h0, 4'h0, 32'h0, 1'b1, 64'h0});
      #1;
      chk("R5", "rd_we on cleared reg", 64'(rd_we), 64'h1);
      chk("R5", "rd_word on cleared reg", rd_word, 64'h0);

      // R2: middle field with single flag (carry only)
      @(negedge clk);
      drive('{1'b1, 2'd1, 3'd5, 8'h00, 64'h0, 4'h2, 32'h0, 1'b0, 64'h0});
      @(posedge clk);
      #1;
      chk("R2", "carry only into field 5", 64'(cr_value), 64'h0000_0000_0000_0200);

      @(negedge clk);
      op_valid = 1'b0;
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(CLK_HALF * 2.0 * 100000.0);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule